// File: doc/BRIEF.md
# Watchdog Supervisor with Shutdown Escalation

This block supervises a host processor through a single keep-alive line. Every change of level on that line, whether upward or downward, counts as a sign of life and restarts an internal timer. When the line stays quiet for a full timeout interval, the block raises a reset pulse of fixed width. It keeps raising pulses, one per timeout interval, for as long as the host stays silent.

A mode input chooses between two behaviours. In standard mode the pulses repeat with no further action. In advanced mode the block counts consecutive pulses that got no answer. On the fourth one it also raises a shutdown output, which stays high for a fixed interval (one second at the default clock) and then drops. The count then starts over, so the escalation repeats for as long as the host stays silent.

All intervals are parameters counted in clock cycles. The keep-alive line is asynchronous and passes through a synchronizer before edges are detected. The mode input is sampled only when the timer restarts.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst_i` is high, both outputs are low from the first clock edge on. Leaving reset restarts the timer in standard mode with the unanswered-pulse count at zero.
- R2: With no kick, `wd_rst_o` rises exactly TIMEOUT_CYC clock edges after the timer restarts. The timer restarts at reset release, at the end of each reset pulse, at shutdown release, and when a kick is seen. A kick is seen SYNC_STAGES+1 edges after the input changes.
- R3: A rising and a falling transition on `kick_i` are equally valid kicks. Kicks seen at most TIMEOUT_CYC cycles apart keep `wd_rst_o` low, and this includes a kick arriving on the very edge the timeout would fire.
- R4: Each reset pulse is high for exactly PULSE_CYC cycles. In standard mode the pulses repeat every TIMEOUT_CYC+PULSE_CYC cycles with no limit, and `shdn_o` stays low.
- R5: In advanced mode, `shdn_o` rises on the same edge as the ESC_COUNT-th (default fourth) consecutive unanswered reset pulse. It stays high for exactly SHDN_CYC cycles, and that pulse is still PULSE_CYC wide.
- R6: When shutdown is released, the count returns to zero and the timer restarts. The next pulse comes TIMEOUT_CYC cycles later, and it is counted as the first pulse of a new escalation cycle.
- R7: A kick seen while no pulse is active clears the unanswered-pulse count.
- R8: A kick seen while a reset pulse is active does not shorten the pulse. It is remembered, and it clears the count when the pulse ends.
- R9: `mode_i` (0 = standard, 1 = advanced) is sampled only at a timer restart. Pulses raised while the latched mode is standard do not add to the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous power-on reset, active high |
| kick_i | input | 1 | Asynchronous keep-alive line from the host |
| mode_i | input | 1 | 0 = standard, 1 = advanced escalation |
| wd_rst_o | output | 1 | Registered reset pulse, active high |
| shdn_o | output | 1 | Registered shutdown, active high |

## Verification
The bound checker checks on every cycle the widths of the reset pulse and the shutdown pulse, and that a pulse never rises before a full timeout of quiet output. It also checks that shutdown only begins together with a reset pulse, that no second pulse starts inside a shutdown, and that reset clears both outputs. The checker cannot see which pulse is the fourth unanswered one, whether a kick cleared the count, or when the mode was sampled. Those are shown only by the bench scenarios, which compare every cycle against an arithmetic model of the pulse schedule.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WD_WATCH = 2'd0,
        WD_PULSE = 2'd1,
        WD_HOLD  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdg_kick_sync.sv
module wdg_kick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic kick_i,
    output logic kick_edge_o
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], kick_i};
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign kick_edge_o = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

endmodule

// File: rtl/wdg_esc_ctrl.sv
module wdg_esc_ctrl
    import wdg_pkg::*;
#(
    parameter int TIMEOUT_CYC = 160_000_000,
    parameter int PULSE_CYC   = 20_000_000,
    parameter int SHDN_CYC    = 100_000_000,
    parameter int ESC_COUNT   = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic kick_edge_i,
    input  logic mode_i,
    output logic wd_rst_o,
    output logic shdn_o
);
    localparam int CNT_MAX = (TIMEOUT_CYC > SHDN_CYC) ?
                             ((TIMEOUT_CYC > PULSE_CYC) ? TIMEOUT_CYC : PULSE_CYC) :
                             ((SHDN_CYC > PULSE_CYC) ? SHDN_CYC : PULSE_CYC);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam int NW = $clog2(ESC_COUNT);

    localparam logic [CW-1:0] TMO_LAST   = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] SHDN_LAST  = CW'(SHDN_CYC - 1);
    localparam logic [NW-1:0] ESC_LAST   = NW'(ESC_COUNT - 1);

    typedef struct packed {
        wd_state_e     state;
        logic [CW-1:0] tmr;
        logic [NW-1:0] missed;
        logic          adv;
        logic          kick_pend;
        logic          rst_out;
        logic          shdn_out;
    } ctrl_s;

    localparam ctrl_s CTRL_RST = '{
        state:     WD_WATCH,
        tmr:       '0,
        missed:    '0,
        adv:       1'b0,
        kick_pend: 1'b0,
        rst_out:   1'b0,
        shdn_out:  1'b0
    };

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            WD_WATCH: begin
                if (kick_edge_i) begin
                    ctl_d.tmr    = '0;
                    ctl_d.missed = '0;
                    ctl_d.adv    = mode_i;
                end else if (ctl_q.tmr == TMO_LAST) begin
                    ctl_d.tmr       = '0;
                    ctl_d.rst_out   = 1'b1;
                    ctl_d.kick_pend = 1'b0;
                    if (ctl_q.adv && (ctl_q.missed == ESC_LAST)) begin
                        ctl_d.state    = WD_HOLD;
                        ctl_d.shdn_out = 1'b1;
                    end else begin
                        ctl_d.state  = WD_PULSE;
                        ctl_d.missed = ctl_q.adv ? (ctl_q.missed + NW'(1)) : '0;
                    end
                end else begin
                    ctl_d.tmr = ctl_q.tmr + CW'(1);
                end
            end
            WD_PULSE: begin
                if (kick_edge_i) begin
                    ctl_d.kick_pend = 1'b1;
                end
                if (ctl_q.tmr == PULSE_LAST) begin
                    ctl_d.state     = WD_WATCH;
                    ctl_d.tmr       = '0;
                    ctl_d.rst_out   = 1'b0;
                    ctl_d.adv       = mode_i;
                    ctl_d.kick_pend = 1'b0;
                    if (ctl_q.kick_pend || kick_edge_i || !mode_i) begin
                        ctl_d.missed = '0;
                    end
                end else begin
                    ctl_d.tmr = ctl_q.tmr + CW'(1);
                end
            end
            WD_HOLD: begin
                if (ctl_q.tmr == PULSE_LAST) begin
                    ctl_d.rst_out = 1'b0;
                end
                if (ctl_q.tmr == SHDN_LAST) begin
                    ctl_d.state    = WD_WATCH;
                    ctl_d.tmr      = '0;
                    ctl_d.shdn_out = 1'b0;
                    ctl_d.rst_out  = 1'b0;
                    ctl_d.missed   = '0;
                    ctl_d.adv      = mode_i;
                end else begin
                    ctl_d.tmr = ctl_q.tmr + CW'(1);
                end
            end
            default: begin
                ctl_d = CTRL_RST;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= CTRL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wd_rst_o = ctl_q.rst_out;
    assign shdn_o   = ctl_q.shdn_out;

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor #(
    parameter int TIMEOUT_CYC = 160_000_000,
    parameter int PULSE_CYC   = 20_000_000,
    parameter int SHDN_CYC    = 100_000_000,
    parameter int ESC_COUNT   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic kick_i,
    input  logic mode_i,
    output logic wd_rst_o,
    output logic shdn_o
);
    logic kick_edge;

    wdg_kick_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i      (clk_i),
        .kick_i     (kick_i),
        .kick_edge_o(kick_edge)
    );

    wdg_esc_ctrl #(
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .SHDN_CYC   (SHDN_CYC),
        .ESC_COUNT  (ESC_COUNT)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .kick_edge_i(kick_edge),
        .mode_i     (mode_i),
        .wd_rst_o   (wd_rst_o),
        .shdn_o     (shdn_o)
    );

endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
    parameter int TIMEOUT_CYC = 160_000_000,
    parameter int PULSE_CYC   = 20_000_000,
    parameter int SHDN_CYC    = 100_000_000
) (
    input logic clk_i,
    input logic rst_i,
    input logic wd_rst_o,
    input logic shdn_o
);
    localparam int CMAX = (TIMEOUT_CYC > SHDN_CYC) ? TIMEOUT_CYC : SHDN_CYC;
    localparam int CW   = $clog2(CMAX + 2);

    logic [CW-1:0] hi_cnt, lo_cnt, sd_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
            sd_cnt <= '0;
        end else begin
            hi_cnt <= wd_rst_o ? hi_cnt + CW'(1) : '0;
            sd_cnt <= shdn_o ? sd_cnt + CW'(1) : '0;
            if (wd_rst_o) begin
                lo_cnt <= '0;
            end else if (lo_cnt < CW'(TIMEOUT_CYC)) begin
                lo_cnt <= lo_cnt + CW'(1);
            end
        end
    end

    AST_RST_CLEARS: assert property (@(posedge clk_i) rst_i |=> (!wd_rst_o && !shdn_o)); // R1
    AST_QUIET_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wd_rst_o) |-> (lo_cnt >= CW'(TIMEOUT_CYC))); // R2
    AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(wd_rst_o) && !$past(rst_i)) |-> (hi_cnt == CW'(PULSE_CYC))); // R4
    AST_SHDN_WITH_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(shdn_o) |-> $rose(wd_rst_o)); // R5
    AST_SHDN_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(shdn_o) && !$past(rst_i)) |-> (sd_cnt == CW'(SHDN_CYC))); // R5
    AST_ONE_PULSE_PER_SHDN: assert property (@(posedge clk_i) disable iff (rst_i)
        (shdn_o && $past(shdn_o)) |-> !$rose(wd_rst_o)); // R6

endmodule

bind wdg_supervisor wdg_supervisor_chk #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .SHDN_CYC   (SHDN_CYC)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wd_rst_o(wd_rst_o),
    .shdn_o  (shdn_o)
);

// File: tb/wdg_supervisor_test.sv
`timescale 1ns/1ps
module wdg_supervisor_test;
    localparam int T   = 10;
    localparam int P   = 4;
    localparam int S   = 20;
    localparam int ESC = 4;
    localparam int L   = T + P;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic kick_i = 1'b0;
    logic mode_i = 1'b0;
    logic wd_rst_o, shdn_o;

    int checks = 0;
    int failures = 0;
    int j = 0;
    int n0 = 0;
    bit adv = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdg_supervisor #(
        .TIMEOUT_CYC(T), .PULSE_CYC(P), .SHDN_CYC(S), .ESC_COUNT(ESC), .SYNC_STAGES(2)
    ) uut (
        .clk_i(clk), .rst_i(rst_i), .kick_i(kick_i), .mode_i(mode_i),
        .wd_rst_o(wd_rst_o), .shdn_o(shdn_o)
    );

    // Expected {shdn, rst} at offset jj after a timer restart.
    function automatic logic [1:0] model(int jj, bit adv_m, int n0_m);
        int pre;
        int p;
        if (!adv_m) begin
            p = jj % L;
            return {1'b0, (p >= T) && (p < L)};
        end
        pre = (ESC - 1 - n0_m) * L;
        while (jj >= pre + T + S) begin
            jj  = jj - (pre + T + S);
            pre = (ESC - 1) * L;
        end
        if (jj < pre) begin
            p = jj % L;
            return {1'b0, (p >= T) && (p < L)};
        end
        p = jj - pre;
        if (p < T) return 2'b00;
        p = p - T;
        return {1'b1, p < P};
    endfunction

    task automatic check(input string tag, input logic [1:0] exp_v);
        checks++;
        if ({shdn_o, wd_rst_o} !== exp_v) begin
            failures++;
            $display("FAIL %s t=%0t j=%0d actual={shdn,rst}=%b expected=%b",
                     tag, $time, j, {shdn_o, wd_rst_o}, exp_v);
        end
    endtask

    task automatic tick_to(input int last, input string tag);
        while (j < last) begin
            @(negedge clk);
            j++;
            check(tag, model(j, adv, n0));
        end
    endtask

    task automatic kick();
        kick_i = ~kick_i;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        // R1: outputs low during reset
        repeat (4) begin
            @(negedge clk);
            check("R1 reset", 2'b00);
        end
        rst_i = 1'b0; j = 0; adv = 1'b0; n0 = 0;
        // R2, R4: standard pulses repeat, no shutdown
        tick_to(5 * L + 1, "R4 std repeat");
        // R9: mode change takes effect only at next restart
        mode_i = 1'b1;
        tick_to(6 * L, "R9 mode latch");
        j = 0; adv = 1'b1; n0 = 0;
        // R5, R6: two escalation cycles
        tick_to(3 * L + T + S + 1, "R5 escalation");
        tick_to(130, "R6 repeat cycle");
        // R1: reset during shutdown
        rst_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1 reset mid-shutdown", 2'b00);
        end
        rst_i = 1'b0; j = 0; adv = 1'b0; n0 = 0;
        // R9: standard default after reset although mode_i=1
        tick_to(L, "R9 std default");
        j = 0; adv = 1'b1; n0 = 0;
        tick_to(2 * L + 2, "R7 pre-kick");
        // R7: kick in watch clears count
        kick();
        tick_to(2 * L + 5, "R7 kick latency");
        j = 0; n0 = 0;
        // R8: kick during pulse recorded
        tick_to(L + T, "R8 pre-kick");
        kick();
        tick_to(2 * L, "R8 pulse full width");
        j = 0; n0 = 0;
        tick_to(3 * L + T + S + 2, "R8 count cleared");
        // R3: both edges, spacing sweep up to the timeout boundary
        for (int d = 4; d <= T; d++) begin
            for (int k = 0; k < 4; k++) begin
                kick();
                for (int c = 0; c < d; c++) begin
                    @(negedge clk);
                    check("R3 kick spacing", 2'b00);
                end
            end
        end
        j = T - 3; adv = 1'b1; n0 = 0;
        // R2: timeout exactly T edges after restart
        tick_to(2 * L + T + 2, "R2 timeout edge");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule